// File: doc/BRIEF.md
# Interleaved Four-Bank Block Refill Engine

This unit refills one cache block of four words after a miss. The block is spread across four word-wide memory banks: the two low bits of a word address pick the bank, and the remaining bits form the block address that every bank shares. When the cache raises a request, the unit latches the block address and the index of the word the processor is waiting for. It then spends one cycle sending that address to all four banks at once. The banks perform their fixed-latency accesses side by side. After that, the unit streams the four words over a single one-word return path, one word per cycle.

Return order is critical-word-first. The word that was asked for comes out in the first beat, and the other three follow in wrap-around index order. Each beat carries a valid strobe and the index of the word it holds, and the fourth beat is flagged as the end of the block. Because the four bank accesses overlap, the whole refill costs one address cycle, plus one access latency, plus four transfer cycles. With the default latency of 25 this is 30 cycles. A bank-by-bank sequence would take 105.

The banks are modelled inside the unit as read-only storage with a fixed access latency. Their contents come from a fixed function of the word address.

Top module: `ibf_fetch_unit`

## Requirements
- R1: While reset is asserted, and until a request is accepted after reset, `busy`, `word_valid` and `last_beat` are all low.
- R2: A request (`req_valid` high while `busy` is low) is accepted at that rising edge. `busy` is high in the next cycle, which is the single address-broadcast cycle.
- R3: While `busy` is high, `req_valid` is ignored. The block being returned, its order and its timing are unchanged, and `busy` still falls after the fourth beat.
- R4: The first data beat appears LATENCY+1 cycles after the address cycle begins. `busy` stays high for exactly 1 + LATENCY + 4 cycles (30 with LATENCY = 25).
- R5: Exactly four data beats are returned, in four consecutive cycles, with `word_valid` high in each.
- R6: Beat k (k = 0..3) carries word index (req_word + k) mod 4. Beat 0 is therefore the requested word, for example 2, 3, 0, 1.
- R7: The beat for word index i carries the content of word address A = req_blk_addr*4 + i, taken from bank i. The content is {~A[15:0], A[15:0]} XOR 32'h3C0000C3.
- R8: `last_beat` is high only together with the fourth beat, and never outside a beat.
- R9: `busy` falls in the cycle after the fourth beat. A request presented in that cycle is accepted, so refills can run back to back with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| req_valid | input | 1 | Refill request strobe |
| req_blk_addr | input | BLK_W | Block address (word address divided by 4) |
| req_word | input | IDX_W | Index of the word the processor needs first |
| busy | output | 1 | Refill in progress; new requests are ignored |
| word_valid | output | 1 | A returned word is on `word_data` |
| word_idx | output | IDX_W | Index of the word on `word_data` (also its bank number) |
| word_data | output | DATA_W | Returned word |
| last_beat | output | 1 | Fourth and final beat of the block |

## Verification
The assertions check every cycle that a request is answered by `busy` in the next cycle, that `last_beat` only ever marks a beat and ends the run of beats, and that beat indices advance by one modulo four. They also check that the bank feeding each beat has finished its access, and that a counter of busy cycles equals 1 + LATENCY + 4 on the last beat. Only the bench scenarios can show that the data content matches the addressed words and that the first beat is the requested word. They also show that requests made while busy leave the block untouched, and that a request in the cycle after the last beat starts a new refill at once.

// File: rtl/ibf_pkg.sv
package ibf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_BEAT = 2'd3
  } ibf_state_e;

  localparam logic [31:0] IBF_SALT = 32'h3C00_00C3;

  // Fixed content of the modelled bank storage, keyed by full word address.
  function automatic logic [31:0] ibf_word_content(input logic [31:0] waddr);
    return {~waddr[15:0], waddr[15:0]} ^ IBF_SALT;
  endfunction

endpackage

// File: rtl/ibf_bank.sv
module ibf_bank
  import ibf_pkg::*;
#(
  parameter int BLK_W   = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 2,
  parameter int BANK_ID = 0,
  parameter int LATENCY = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [BLK_W-1:0]  blk_addr,
  output logic              rdy,
  output logic [DATA_W-1:0] data
);

  localparam int LAT_W = $clog2(LATENCY + 1);
  localparam logic [LAT_W-1:0] LAT_END = LAT_W'(LATENCY - 1);

  logic              act_q, act_n;
  logic [LAT_W-1:0]  cnt_q, cnt_n;
  logic              rdy_q, rdy_n;
  logic [BLK_W-1:0]  addr_q;
  logic [DATA_W-1:0] data_q, data_n;
  logic              addr_en, data_en;

  always_comb begin
    act_n   = act_q;
    cnt_n   = cnt_q;
    rdy_n   = rdy_q;
    data_n  = data_q;
    addr_en = 1'b0;
    data_en = 1'b0;
    if (strobe) begin
      act_n   = 1'b1;
      cnt_n   = '0;
      rdy_n   = 1'b0;
      addr_en = 1'b1;
    end else if (act_q) begin
      if (cnt_q == LAT_END) begin
        act_n   = 1'b0;
        rdy_n   = 1'b1;
        data_en = 1'b1;
        data_n  = DATA_W'(ibf_word_content(32'({addr_q, IDX_W'(BANK_ID)})));
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      rdy_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      rdy_q <= rdy_n;
      if (addr_en) addr_q <= blk_addr;
      if (data_en) data_q <= data_n;
    end
  end

  assign rdy  = rdy_q;
  assign data = data_q;

endmodule

// File: rtl/ibf_ctrl.sv
module ibf_ctrl
  import ibf_pkg::*;
#(
  parameter int NBANKS  = 4,
  parameter int LATENCY = 25
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [$clog2(NBANKS)-1:0] req_word,
  output logic                      accept,
  output logic                      strobe,
  output logic                      busy,
  output logic                      beat_valid,
  output logic                      beat_last,
  output logic [$clog2(NBANKS)-1:0] beat_sel
);

  localparam int IDX_W = $clog2(NBANKS);
  localparam int LAT_W = $clog2(LATENCY + 1);
  localparam logic [LAT_W-1:0] LAT_END  = LAT_W'(LATENCY - 1);
  localparam logic [IDX_W-1:0] BEAT_END = IDX_W'(NBANKS - 1);

  ibf_state_e       st_q, st_n;
  logic [LAT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] beat_q, beat_n;
  logic [IDX_W-1:0] crit_q, crit_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    beat_n = beat_q;
    crit_n = crit_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        st_n   = ST_ADDR;
        crit_n = req_word;
      end
      ST_ADDR: begin
        st_n  = ST_WAIT;
        cnt_n = '0;
      end
      ST_WAIT: if (cnt_q == LAT_END) begin
        st_n   = ST_BEAT;
        beat_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
      ST_BEAT: if (beat_q == BEAT_END) begin
        st_n = ST_IDLE;
      end else begin
        beat_n = beat_q + 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
      crit_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      beat_q <= beat_n;
      crit_q <= crit_n;
    end
  end

  assign accept     = (st_q == ST_IDLE) && req_valid;
  assign strobe     = (st_q == ST_ADDR);
  assign busy       = (st_q != ST_IDLE);
  assign beat_valid = (st_q == ST_BEAT);
  assign beat_last  = (st_q == ST_BEAT) && (beat_q == BEAT_END);
  // NBANKS is a power of two, so the sum wraps modulo NBANKS.
  assign beat_sel   = crit_q + beat_q;

endmodule

// File: rtl/ibf_fetch_unit.sv
module ibf_fetch_unit
  import ibf_pkg::*;
#(
  parameter int BLK_W   = 8,
  parameter int DATA_W  = 32,
  parameter int NBANKS  = 4,
  parameter int LATENCY = 25,
  localparam int IDX_W  = $clog2(NBANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BLK_W-1:0]  req_blk_addr,
  input  logic [IDX_W-1:0]  req_word,
  output logic              busy,
  output logic              word_valid,
  output logic [IDX_W-1:0]  word_idx,
  output logic [DATA_W-1:0] word_data,
  output logic              last_beat
);

  logic [1:0]        rst_sync_q;
  logic              rst_ok;
  logic              accept, strobe;
  logic [BLK_W-1:0]  blk_q;
  logic [NBANKS-1:0] bank_rdy;
  logic [DATA_W-1:0] bank_data [NBANKS];

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  ibf_ctrl #(
    .NBANKS  (NBANKS),
    .LATENCY (LATENCY)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_ok),
    .req_valid  (req_valid),
    .req_word   (req_word),
    .accept     (accept),
    .strobe     (strobe),
    .busy       (busy),
    .beat_valid (word_valid),
    .beat_last  (last_beat),
    .beat_sel   (word_idx)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)     blk_q <= '0;
    else if (accept) blk_q <= req_blk_addr;
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    ibf_bank #(
      .BLK_W   (BLK_W),
      .DATA_W  (DATA_W),
      .IDX_W   (IDX_W),
      .BANK_ID (b),
      .LATENCY (LATENCY)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_ok),
      .strobe   (strobe),
      .blk_addr (blk_q),
      .rdy      (bank_rdy[b]),
      .data     (bank_data[b])
    );
  end

  assign word_data = bank_data[word_idx];

endmodule

// File: rtl/ibf_fetch_chk.sv
module ibf_fetch_chk #(
  parameter int NBANKS  = 4,
  parameter int LATENCY = 25,
  localparam int IDX_W  = $clog2(NBANKS),
  localparam int TOTAL  = 1 + LATENCY + NBANKS,
  localparam int CNT_W  = $clog2(TOTAL + 1) + 1
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              req_valid,
  input logic              busy,
  input logic              word_valid,
  input logic [IDX_W-1:0]  word_idx,
  input logic              last_beat,
  input logic [NBANKS-1:0] bank_rdy
);

  logic [CNT_W-1:0] busy_cnt_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)   busy_cnt_q <= '0;
    else if (busy) busy_cnt_q <= busy_cnt_q + 1'b1;
    else           busy_cnt_q <= '0;
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && !busy) |=> busy);

  // R8
  last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    last_beat |-> word_valid);

  // R5
  beat_run_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (word_valid && !last_beat) |=> word_valid);

  // R8
  last_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    last_beat |=> !word_valid);

  // R6
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (word_valid && !last_beat) |=> (word_idx == IDX_W'($past(word_idx) + 1'b1)));

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    last_beat |=> !busy);

  // R4
  refill_len_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    last_beat |-> (busy_cnt_q == CNT_W'(TOTAL - 1)));

  // R7
  bank_ready_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    word_valid |-> bank_rdy[word_idx]);

endmodule

bind ibf_fetch_unit ibf_fetch_chk #(
  .NBANKS  (NBANKS),
  .LATENCY (LATENCY)
) u_fetch_chk (
  .clk        (clk),
  .rst_ok     (rst_ok),
  .req_valid  (req_valid),
  .busy       (busy),
  .word_valid (word_valid),
  .word_idx   (word_idx),
  .last_beat  (last_beat),
  .bank_rdy   (bank_rdy)
);

// File: tb/test_ibf_fetch_unit.sv
`timescale 1ns/1ps
module test_ibf_fetch_unit;

  localparam int BLK_W   = 8;
  localparam int DATA_W  = 32;
  localparam int NBANKS  = 4;
  localparam int LATENCY = 25;
  localparam int IDX_W   = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [BLK_W-1:0]  req_blk_addr;
  logic [IDX_W-1:0]  req_word;
  logic              busy, word_valid, last_beat;
  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] word_data;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ibf_fetch_unit #(
    .BLK_W(BLK_W), .DATA_W(DATA_W), .NBANKS(NBANKS), .LATENCY(LATENCY)
  ) i_ibf_fetch_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk_addr(req_blk_addr),
    .req_word(req_word), .busy(busy), .word_valid(word_valid), .word_idx(word_idx),
    .word_data(word_data), .last_beat(last_beat)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input int blk, input int idx);
    logic [31:0] a;
    a = 32'(blk * 4 + idx);
    return {~a[15:0], a[15:0]} ^ 32'h3C00_00C3;
  endfunction

  // One refill; optional stray requests while busy (R3).
  task automatic run_fetch(input int blk, input int wrd, input bit stray);
    int cyc = 0;
    int k = 0;
    int first = 0;
    int exp_idx;
    chk(busy == 1'b0, "R9", "busy low before request", busy, 0);
    req_valid    = 1'b1;
    req_blk_addr = BLK_W'(blk);
    req_word     = IDX_W'(wrd);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    chk(busy == 1'b1, "R2", "busy in address cycle", busy, 1);
    chk(word_valid == 1'b0, "R2", "no beat in address cycle", word_valid, 0);
    while (busy && cyc < 200) begin
      req_valid = 1'b0;
      if (word_valid) begin
        if (k == 0) first = cyc;
        exp_idx = (wrd + k) % NBANKS;
        chk(int'(word_idx) == exp_idx, "R6", "beat index", word_idx, exp_idx);
        chk(word_data == expect_word(blk, exp_idx), "R7", "beat data",
            word_data, expect_word(blk, exp_idx));
        chk(last_beat == (k == NBANKS - 1), "R8", "last flag", last_beat, k == NBANKS - 1);
        chk(cyc == LATENCY + 2 + k, "R5", "beat cycle", cyc, LATENCY + 2 + k);
        k++;
      end else begin
        chk(last_beat == 1'b0, "R8", "last flag outside beat", last_beat, 0);
      end
      if (stray && (cyc == 1 || cyc == 10 || cyc == LATENCY + 5)) begin
        req_valid    = 1'b1;
        req_blk_addr = ~BLK_W'(blk);
        req_word     = IDX_W'(wrd + 1);
      end
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(first == LATENCY + 2, "R4", "first beat cycle", first, LATENCY + 2);
    chk(cyc - 1 == 1 + LATENCY + 4, "R4", "busy length", cyc - 1, 1 + LATENCY + 4);
    chk(k == NBANKS, "R5", "beat count", k, NBANKS);
    if (stray) chk(busy == 1'b0, "R3", "stray request not accepted", busy, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_blk_addr = '0;
    req_word = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(word_valid == 1'b0, "R1", "valid in reset", word_valid, 0);
    chk(last_beat == 1'b0, "R1", "last in reset", last_beat, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(word_valid == 1'b0, "R1", "valid after reset", word_valid, 0);
  endtask

  task automatic t_back_to_back();
    run_fetch(8'h11, 1, 1'b0);
    // R9: request in the cycle right after the last beat starts a new refill.
    run_fetch(8'h12, 0, 1'b0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    t_reset();
    run_fetch(8'h00, 0, 1'b0);
    run_fetch(8'h4B, 2, 1'b0);
    run_fetch(8'hFF, 3, 1'b1);
    run_fetch(8'h80, 1, 1'b1);
    t_back_to_back();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

endmodule